// File: doc/BRIEF.md
# Checkpoint-Gated Device Write Buffer

This block sits between a processor core and its devices in a system that recovers from hardware faults by rolling back to a saved checkpoint. A device write cannot be undone, so writes from the core are held here until the checkpoint interval that issued them has been declared fault-free. Only then are they released to the device. Device read results are kept in a log. After a rollback, the re-executed code receives the same values it saw the first time, and the device is not touched again.

Two checkpoint intervals are in flight at any time: the older one, which is waiting for its verdict, and the current one, which is still executing. A boundary pulse closes the current interval and makes it the older one. A validate pulse releases the older interval's writes and frees its read-log entries. A rollback pulse throws away every write that has not been released and replays the read log from the start of the oldest unvalidated interval. The buffer is sized for short intervals, so both stores stay small: the default is sixteen 40-bit write entries and sixteen 32-bit read entries.

Top module: `ckpt_out_buf`

## Requirements
- R1: In the cycle after reset, dev_wr_valid and core_rd_valid are 0, and core_wr_ready and core_rd_ready are 1.
- R2: A core write is never shown on the device side until a boundary pulse has closed its interval and a later validate pulse has accepted that interval. Accepted writes leave in the order the core issued them. Writes of the still-open interval stay held.
- R3: A write is accepted only in a cycle where core_wr_valid and core_wr_ready are both 1. When WR_DEPTH accepted entries are waiting (entries not yet moved into the device output register), core_wr_ready is 0 from the next cycle on. No accepted write is ever lost, except by rollback.
- R4: A rollback pulse discards every accepted write that has not been released, including a write offered in the same cycle. Writes that were already released are still delivered in order.
- R5: A validate pulse is ignored while no closed interval is waiting. A boundary pulse is ignored while a closed interval is still waiting for its verdict.
- R6: An accepted read outside replay drives dev_rd_en to 1 in that same cycle. In the next cycle core_rd_valid is 1 and core_rd_data equals the dev_rd_data sampled with the request.
- R7: After a rollback, accepted reads are served from the log in their original order, starting at the oldest unvalidated interval. They use the same one-cycle latency and keep dev_rd_en at 0. Once the log is used up, reads go to the device again.
- R8: A validate pulse frees the read-log entries of the accepted interval, and a later rollback does not replay them.
- R9: While dev_wr_valid is 1 and dev_wr_ready is 0, dev_wr_valid, dev_wr_addr and dev_wr_data hold their values.
- R10: When RD_DEPTH read entries are logged and no replay is in progress, core_rd_ready is 0 until a validate pulse frees space.
- R11: A rollback pulse takes priority: a validate or boundary pulse in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ckpt_i | input | 1 | Interval boundary pulse |
| validate_i | input | 1 | Older interval declared fault-free |
| rollback_i | input | 1 | Restore to last validated checkpoint |
| core_wr_valid | input | 1 | Core offers a device write |
| core_wr_addr | input | ADDR_W | Device write address |
| core_wr_data | input | DATA_W | Device write data |
| core_wr_ready | output | 1 | Buffer can accept a write |
| dev_wr_valid | output | 1 | Released write presented to device |
| dev_wr_addr | output | ADDR_W | Released write address |
| dev_wr_data | output | DATA_W | Released write data |
| dev_wr_ready | input | 1 | Device takes the presented write |
| core_rd_en | input | 1 | Core issues a device read |
| core_rd_ready | output | 1 | Read can be accepted |
| dev_rd_en | output | 1 | Read forwarded to the device |
| dev_rd_data | input | DATA_W | Device read data, same cycle as dev_rd_en |
| core_rd_valid | output | 1 | Read result available |
| core_rd_data | output | DATA_W | Read result, live or replayed |

## Verification
A wrong boundary or release pointer shows up on the device port within a few cycles of the next validate pulse. Writes then appear too early, too late, duplicated or out of order, and the reference model flags the first wrong dev_wr_addr or dev_wr_data on the clock where it appears. A corrupted read-log pointer stays hidden until the next rollback. Only then do the replayed core_rd_data values, or a stray dev_rd_en, diverge from the model, one cycle after the first replayed request. A wrong occupancy count shows as a mistimed core_wr_ready or core_rd_ready in the cycle after the buffer fills or drains.

// File: rtl/cob_pkg.sv
package cob_pkg;

  // Effective control strobes after priority and pending-interval qualification.
  typedef struct packed {
    logic rb;    // discard unreleased state, restart replay
    logic val;   // older interval accepted
    logic ckpt;  // current interval closed
  } cob_strobe_t;

endpackage

// File: rtl/cob_interval_ctl.sv
module cob_interval_ctl
  import cob_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ckpt_i,
  input  logic        val_i,
  input  logic        rb_i,
  output cob_strobe_t str_o
);

  logic old_q;     // a closed interval awaits its verdict
  logic val_ok;
  logic ckpt_ok;

  always_comb begin
    val_ok  = val_i & old_q & ~rb_i;
    ckpt_ok = ckpt_i & ~rb_i & (~old_q | val_ok);
    str_o.rb   = rb_i;
    str_o.val  = val_ok;
    str_o.ckpt = ckpt_ok;
  end

  always_ff @(posedge clk) begin
    if (rst)          old_q <= 1'b0;
    else if (rb_i)    old_q <= 1'b0;
    else if (ckpt_ok) old_q <= 1'b1;
    else if (val_ok)  old_q <= 1'b0;
  end

endmodule

// File: rtl/cob_wr_queue.sv
module cob_wr_queue
  import cob_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cob_strobe_t       str_i,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  localparam int PW = $clog2(DEPTH);
  localparam int EW = ADDR_W + DATA_W;
  localparam logic [PW:0] CAP = (PW+1)'(DEPTH);
  localparam logic [PW:0] ONE = (PW+1)'(1);

  typedef logic [PW:0] ptr_t;

  // Ring regions: [head,rel) released, [rel,bnd) older interval, [bnd,tail) current.
  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] out_q;
  ptr_t head_q, rel_q, bnd_q, tail_q;
  ptr_t head_n, rel_n, bnd_n, tail_n;
  logic push, load;

  assign push = in_valid & in_ready & ~str_i.rb;
  assign load = (~out_valid | out_ready) & (head_q != rel_q);

  always_comb begin
    head_n = load ? head_q + ONE : head_q;
    tail_n = push ? tail_q + ONE : tail_q;
    rel_n  = rel_q;
    bnd_n  = bnd_q;
    if (str_i.rb) begin
      tail_n = rel_q;
      bnd_n  = rel_q;
    end else begin
      if (str_i.val)  rel_n = bnd_q;
      if (str_i.ckpt) bnd_n = tail_q;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[tail_q[PW-1:0]] <= {in_addr, in_data};
  end

  always_ff @(posedge clk) begin
    if (load) out_q <= mem[head_q[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      rel_q     <= '0;
      bnd_q     <= '0;
      tail_q    <= '0;
      in_ready  <= 1'b1;
      out_valid <= 1'b0;
    end else begin
      head_q    <= head_n;
      rel_q     <= rel_n;
      bnd_q     <= bnd_n;
      tail_q    <= tail_n;
      in_ready  <= (tail_n - head_n) != CAP;
      out_valid <= load | (out_valid & ~out_ready);
    end
  end

  assign {out_addr, out_data} = out_q;

  // R3: a full ring never offers a free slot
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ((tail_q - head_q) == CAP) |-> !in_ready);

  // R2: released region precedes the older interval, which precedes the current one
  p_region_order_r2: assert property (@(posedge clk) disable iff (rst)
    ((rel_q - head_q) <= (bnd_q - head_q)) && ((bnd_q - head_q) <= (tail_q - head_q)));

  // R9: presented write holds until taken
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));

endmodule

// File: rtl/cob_rd_log.sv
module cob_rd_log
  import cob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cob_strobe_t       str_i,
  input  logic              req_i,
  output logic              ready_o,
  output logic              fetch_o,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] CAP = (PW+1)'(DEPTH);
  localparam logic [PW:0] ONE = (PW+1)'(1);

  typedef logic [PW:0] ptr_t;

  // [head,bnd) older interval, [bnd,tail) current; rep walks the log during replay.
  logic [DATA_W-1:0] mem [DEPTH];
  ptr_t head_q, bnd_q, tail_q, rep_q;
  ptr_t head_n, bnd_n, tail_n, rep_n;
  logic replay_q, replay_n;
  logic fire, live, redo;

  assign fire    = req_i & ready_o & ~str_i.rb;
  assign live    = fire & ~replay_q;
  assign redo    = fire & replay_q;
  assign fetch_o = live;

  always_comb begin
    head_n   = head_q;
    bnd_n    = bnd_q;
    tail_n   = live ? tail_q + ONE : tail_q;
    rep_n    = rep_q;
    replay_n = replay_q;
    if (str_i.rb) begin
      rep_n    = head_q;
      bnd_n    = head_q;
      replay_n = (head_q != tail_q);
    end else begin
      if (str_i.val)  head_n = bnd_q;
      if (str_i.ckpt) bnd_n  = replay_q ? rep_q : tail_q;
      if (redo) begin
        rep_n = rep_q + ONE;
        if (rep_q + ONE == tail_q) replay_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (live) mem[tail_q[PW-1:0]] <= fetch_data_i;
  end

  always_ff @(posedge clk) begin
    if (live)      data_o <= fetch_data_i;
    else if (redo) data_o <= mem[rep_q[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= '0;
      bnd_q    <= '0;
      tail_q   <= '0;
      rep_q    <= '0;
      replay_q <= 1'b0;
      valid_o  <= 1'b0;
      ready_o  <= 1'b1;
    end else begin
      head_q   <= head_n;
      bnd_q    <= bnd_n;
      tail_q   <= tail_n;
      rep_q    <= rep_n;
      replay_q <= replay_n;
      valid_o  <= fire;
      ready_o  <= replay_n | ((tail_n - head_n) != CAP);
    end
  end

  // R10: full log outside replay stalls the core
  p_log_full_r10: assert property (@(posedge clk) disable iff (rst)
    (((tail_q - head_q) == CAP) && !replay_q) |-> !ready_o);

  // R7: replay cursor always points at a logged entry
  p_replay_inside_r7: assert property (@(posedge clk) disable iff (rst)
    replay_q |-> ((rep_q - head_q) < (tail_q - head_q)));

  // R8: the older interval never extends past the log tail
  p_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (bnd_q - head_q) <= (tail_q - head_q));

endmodule

// File: rtl/ckpt_out_buf.sv
module ckpt_out_buf
  import cob_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int WR_DEPTH = 16,
  parameter int RD_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ckpt_i,
  input  logic              validate_i,
  input  logic              rollback_i,
  input  logic              core_wr_valid,
  input  logic [ADDR_W-1:0] core_wr_addr,
  input  logic [DATA_W-1:0] core_wr_data,
  output logic              core_wr_ready,
  output logic              dev_wr_valid,
  output logic [ADDR_W-1:0] dev_wr_addr,
  output logic [DATA_W-1:0] dev_wr_data,
  input  logic              dev_wr_ready,
  input  logic              core_rd_en,
  output logic              core_rd_ready,
  output logic              dev_rd_en,
  input  logic [DATA_W-1:0] dev_rd_data,
  output logic              core_rd_valid,
  output logic [DATA_W-1:0] core_rd_data
);

  cob_strobe_t str;

  cob_interval_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .ckpt_i (ckpt_i),
    .val_i  (validate_i),
    .rb_i   (rollback_i),
    .str_o  (str)
  );

  cob_wr_queue #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (WR_DEPTH)
  ) u_wq (
    .clk       (clk),
    .rst       (rst),
    .str_i     (str),
    .in_valid  (core_wr_valid),
    .in_addr   (core_wr_addr),
    .in_data   (core_wr_data),
    .in_ready  (core_wr_ready),
    .out_valid (dev_wr_valid),
    .out_addr  (dev_wr_addr),
    .out_data  (dev_wr_data),
    .out_ready (dev_wr_ready)
  );

  cob_rd_log #(
    .DATA_W (DATA_W),
    .DEPTH  (RD_DEPTH)
  ) u_rl (
    .clk          (clk),
    .rst          (rst),
    .str_i        (str),
    .req_i        (core_rd_en),
    .ready_o      (core_rd_ready),
    .fetch_o      (dev_rd_en),
    .fetch_data_i (dev_rd_data),
    .valid_o      (core_rd_valid),
    .data_o       (core_rd_data)
  );

endmodule

// File: tb/ckpt_out_buf_tb.sv
module ckpt_out_buf_tb;
  localparam int AW = 8, DW = 32, WD = 16, RD = 16;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic ckpt_i = 0, validate_i = 0, rollback_i = 0;
  logic core_wr_valid = 0; logic [AW-1:0] core_wr_addr = '0; logic [DW-1:0] core_wr_data = '0;
  logic core_wr_ready, dev_wr_valid; logic [AW-1:0] dev_wr_addr; logic [DW-1:0] dev_wr_data;
  logic dev_wr_ready = 1;
  logic core_rd_en = 0, core_rd_ready, dev_rd_en; logic [DW-1:0] dev_rd_data = '0;
  logic core_rd_valid; logic [DW-1:0] core_rd_data;

  ckpt_out_buf #(.ADDR_W(AW), .DATA_W(DW), .WR_DEPTH(WD), .RD_DEPTH(RD)) u_dut (
    .clk(clk), .rst(rst), .ckpt_i(ckpt_i), .validate_i(validate_i), .rollback_i(rollback_i),
    .core_wr_valid(core_wr_valid), .core_wr_addr(core_wr_addr), .core_wr_data(core_wr_data),
    .core_wr_ready(core_wr_ready), .dev_wr_valid(dev_wr_valid), .dev_wr_addr(dev_wr_addr),
    .dev_wr_data(dev_wr_data), .dev_wr_ready(dev_wr_ready), .core_rd_en(core_rd_en),
    .core_rd_ready(core_rd_ready), .dev_rd_en(dev_rd_en), .dev_rd_data(dev_rd_data),
    .core_rd_valid(core_rd_valid), .core_rd_data(core_rd_data));

  int checks = 0, bad = 0, ncyc = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [39:0] q_rel[$], q_old[$], q_cur[$], got[$];
  logic [31:0] logv[$];
  bit m_old, m_dv, m_wr_ready, m_rd_ready, m_rv, m_rep;
  logic [39:0] m_dw; logic [31:0] m_rd;
  int m_bnd, m_ri;

  always @(posedge clk) begin
    bit rb, val, ck, wacc, racc;
    ncyc++;
    if (ncyc > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
    if (dev_wr_valid === 1'b1 && dev_wr_ready) got.push_back({dev_wr_addr, dev_wr_data});
    if (rst) begin
      q_rel.delete(); q_old.delete(); q_cur.delete(); logv.delete();
      m_old = 0; m_dv = 0; m_wr_ready = 1; m_rd_ready = 1; m_rv = 0; m_rep = 0;
      m_bnd = 0; m_ri = 0;
    end else begin
      // R6/R7: forwarding to the device only for live accepted reads
      chk("R6/R7", "dev_rd_en", dev_rd_en, core_rd_en & m_rd_ready & ~m_rep & ~rollback_i);
      rb   = rollback_i;
      val  = validate_i & m_old & ~rb;
      ck   = ckpt_i & ~rb & (~m_old | val);
      wacc = core_wr_valid & m_wr_ready & ~rb;
      racc = core_rd_en & m_rd_ready & ~rb;
      if (m_dv && dev_wr_ready) m_dv = 0;
      if (!m_dv && q_rel.size() > 0) begin m_dv = 1; m_dw = q_rel.pop_front(); end
      if (rb) begin
        q_old.delete(); q_cur.delete();
        m_bnd = 0; m_ri = 0; m_rep = (logv.size() > 0);
      end else begin
        if (val) begin
          while (q_old.size() > 0) q_rel.push_back(q_old.pop_front());
          repeat (m_bnd) void'(logv.pop_front());
          m_ri -= m_bnd; m_bnd = 0;
        end
        if (ck) begin
          q_old = q_cur; q_cur.delete();
          m_bnd = m_rep ? m_ri : logv.size();
        end
        if (wacc) q_cur.push_back({core_wr_addr, core_wr_data});
        if (racc) begin
          if (m_rep) begin
            m_rd = logv[m_ri]; m_ri++;
            if (m_ri == logv.size()) m_rep = 0;
          end else begin
            m_rd = dev_rd_data; logv.push_back(dev_rd_data);
          end
        end
      end
      m_old = rb ? 1'b0 : ck ? 1'b1 : val ? 1'b0 : m_old;
      m_rv = racc;
      m_wr_ready = (q_rel.size() + q_old.size() + q_cur.size()) < WD;
      m_rd_ready = m_rep || (logv.size() < RD);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R3", "core_wr_ready", core_wr_ready, m_wr_ready);
      chk("R2", "dev_wr_valid", dev_wr_valid, m_dv);
      if (m_dv) chk("R2/R9", "dev_wr_word", {dev_wr_addr, dev_wr_data}, m_dw);
      chk("R10", "core_rd_ready", core_rd_ready, m_rd_ready);
      chk("R6", "core_rd_valid", core_rd_valid, m_rv);
      if (m_rv) chk("R7", "core_rd_data", core_rd_data, m_rd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    core_wr_valid = 1; core_wr_addr = a; core_wr_data = d;
    while (!core_wr_ready) @(negedge clk);
    @(negedge clk);
    core_wr_valid = 0;
  endtask

  task automatic rd(input logic [31:0] v, output logic [31:0] r);
    core_rd_en = 1; dev_rd_data = v;
    while (!core_rd_ready) @(negedge clk);
    @(negedge clk);
    core_rd_en = 0;
    chk("R6", "rd_valid after request", core_rd_valid, 1);
    r = core_rd_data;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: ckpt_i = 1;
      1: validate_i = 1;
      default: rollback_i = 1;
    endcase
    @(negedge clk);
    ckpt_i = 0; validate_i = 0; rollback_i = 0;
  endtask

  initial begin
    logic [31:0] r;
    cyc(3);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1", "dev_wr_valid", dev_wr_valid, 0);
    chk("R1", "core_wr_ready", core_wr_ready, 1);
    chk("R1", "core_rd_ready", core_rd_ready, 1);
    chk("R1", "core_rd_valid", core_rd_valid, 0);

    // R2: held until closed and validated, then in order
    wr(8'h10, 32'h100); wr(8'h11, 32'h101); wr(8'h12, 32'h102);
    cyc(5);
    chk("R2", "writes before verdict", got.size(), 0);
    pulse(0);
    wr(8'h20, 32'h200); wr(8'h21, 32'h201);
    pulse(1);
    cyc(6);
    chk("R2", "released count", got.size(), 3);
    chk("R2", "first released", got[0], {8'h10, 32'h100});
    chk("R2", "last released", got[2], {8'h12, 32'h102});

    // R5: stray validate and double boundary ignored
    pulse(1); cyc(4);
    chk("R5", "validate with nothing pending", got.size(), 3);
    pulse(0); pulse(0);
    wr(8'h30, 32'h300);
    pulse(1); cyc(6);
    chk("R5", "second boundary ignored", got.size(), 5);
    pulse(0); pulse(1); cyc(6);
    chk("R5", "late write released", got.size(), 6);

    // R9: device stall
    dev_wr_ready = 0;
    wr(8'h40, 32'h400); wr(8'h41, 32'h401);
    pulse(0); pulse(1); cyc(5);
    chk("R9", "stalled valid", dev_wr_valid, 1);
    chk("R9", "stalled addr", dev_wr_addr, 8'h40);
    dev_wr_ready = 1; cyc(4);
    chk("R9", "after stall", got.size(), 8);

    // R3: fill, then R4 rollback empties
    dev_wr_ready = 0;
    core_wr_valid = 1;
    for (int i = 0; i < 20; i++) begin
      core_wr_addr = 8'h50 + 8'(i); core_wr_data = 32'(i);
      @(negedge clk);
    end
    core_wr_valid = 0;
    chk("R3", "full backpressure", core_wr_ready, 0);
    pulse(2); cyc(2);
    chk("R4", "ready after discard", core_wr_ready, 1);
    dev_wr_ready = 1; cyc(4);
    chk("R4", "discarded never sent", got.size(), 8);

    // R4: released survive a rollback
    dev_wr_ready = 0;
    wr(8'h70, 32'h700); wr(8'h71, 32'h701);
    pulse(0); pulse(1);
    wr(8'h72, 32'h702);
    pulse(2);
    dev_wr_ready = 1; cyc(6);
    chk("R4", "released kept", got.size(), 10);
    chk("R4", "last delivered", got[9][39:32], 8'h71);

    // R6 live reads, R8 validated reads dropped, R7 replay
    rd(32'hA1, r); chk("R6", "live data", r, 32'hA1);
    rd(32'hA2, r); rd(32'hA3, r);
    pulse(0);
    rd(32'hB1, r); rd(32'hB2, r);
    pulse(1);
    rd(32'hC1, r);
    pulse(2);
    rd(32'hDEAD, r); chk("R8", "replay skips validated", r, 32'hB1);
    rd(32'hDEAD, r); chk("R7", "replay second", r, 32'hB2);
    rd(32'hDEAD, r); chk("R7", "replay third", r, 32'hC1);
    rd(32'h55, r);   chk("R7", "live after replay", r, 32'h55);

    // R11: rollback beats validate
    wr(8'h80, 32'h800);
    pulse(0);
    wr(8'h81, 32'h801);
    rollback_i = 1; validate_i = 1;
    @(negedge clk);
    rollback_i = 0; validate_i = 0;
    cyc(6);
    chk("R11", "validate ignored under rollback", got.size(), 10);

    // R10: read log fills
    core_rd_en = 1;
    for (int i = 0; i < 30; i++) begin
      dev_rd_data = 32'h1000 + 32'(i);
      @(negedge clk);
    end
    core_rd_en = 0;
    chk("R10", "log full stall", core_rd_ready, 0);
    pulse(0); pulse(1); cyc(2);
    chk("R10", "space after validate", core_rd_ready, 1);

    // Mixed traffic against the model (R2 R3 R4 R7)
    for (int i = 0; i < 4000; i++) begin
      core_wr_valid = 1'($urandom);
      core_wr_addr  = 8'($urandom);
      core_wr_data  = $urandom;
      core_rd_en    = 1'($urandom);
      dev_rd_data   = $urandom;
      dev_wr_ready  = ($urandom % 4) != 0;
      ckpt_i        = ($urandom % 23) == 0;
      validate_i    = ($urandom % 19) == 0;
      rollback_i    = ($urandom % 97) == 0;
      @(negedge clk);
    end
    core_wr_valid = 0; core_rd_en = 0; ckpt_i = 0; validate_i = 0; rollback_i = 0;
    dev_wr_ready = 1;
    cyc(4);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule